// File: doc/BRIEF.md
# Store Queue with Commit-Driven Write-Back

This block holds in-flight stores of an out-of-order core in a circular buffer with one spare slot, so that equal head and tail pointers always mean "empty". Stores enter at the tail in program order. Each one records its own slot index and the load-queue tail position at the moment it arrived, which the load side uses as an ordering tag. An execute port later fills in the address, the data, a byte count and two flags: store-conditional and prefetch.

A store becomes writable in one of two ways. The commit stage names the youngest committed sequence number, or a store-conditional executes without a fault. A separate write-back pointer sends writable stores to the data cache one at a time in program order over a valid/ready request. A refused request stays on the same entry until it is accepted. Stores of zero bytes and prefetch stores complete on the spot and send nothing. The cache reports finished writes on a completion input. The retire head then moves over every completed entry in a row, so completions that arrive out of order are retired together once the oldest one lands.

A squash trims uncommitted stores from the young end of the queue. A load that is waiting on one particular store can be registered as stalled. When that store's write is accepted, or when the store completes, the block raises a one-cycle replay pulse carrying the load's index.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty (`sqEmpty`=1, `sqFull`=0), `allocIdx` is 0, and neither `wrValid` nor `replayValid` is asserted.
- R2: The queue holds CAPACITY stores in CAPACITY+1 slots. `allocIdx` is the slot the next store takes and advances by one, modulo CAPACITY+1, per accepted allocation. When `sqFull` is set, an allocation is ignored and `allocIdx` stays unchanged.
- R3: A store that is neither committed nor a fault-free store-conditional never produces a write request.
- R4: A commit scans from the oldest entry. It marks writable every not-yet-writable entry up to the first not-yet-writable entry whose sequence number is greater than `commitSeq`, where the scan stops. Newly writable entries can be requested from the next cycle on.
- R5: A store-conditional executed with `exeFault`=0 becomes writable without a commit. One executed with `exeFault`=1 does not.
- R6: Write requests go out one per cycle in slot order. Each carries the slot index, the address, the data, the recorded load-queue tail and a byte mask equal to ((1<<size)-1) shifted left by the address's three low bits, truncated to 8 bits. Size is a byte count from 0 to 8.
- R7: While `wrValid` is high and `wrReady` is low, the same request is held in the next cycle.
- R8: A writable store of size 0, or with the prefetch flag set, sends no request. It completes in the cycle the write-back pointer reaches it, and the pointer then moves on.
- R9: A completion marks its entry done. The oldest entry and every done entry directly behind it retire together, while a done entry behind an unfinished older one is kept.
- R10: A squash removes entries from the young end whose sequence number is greater than `squashSeq`. It stops at the first writable entry and never removes one. An allocation in the same cycle as a squash is ignored.
- R11: With a stall registered by `stallSet`, an accepted write request of the store whose sequence number is `stallSeq`, or the completion of that store, clears the stall. `replayValid` then pulses one cycle later with the registered `stallLoadIdx`.
- R12: A commit and a completion in the same cycle both take effect: the head retires and the newly committed stores become requestable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a store at the tail |
| allocSeq | input | SEQ_W | Sequence number of the new store |
| allocLqTail | input | LQ_W | Load-queue tail at allocation |
| allocIdx | output | IDX_W | Slot the next store takes |
| sqFull | output | 1 | No free slot |
| sqEmpty | output | 1 | No store held |
| exeValid | input | 1 | Execute result for a slot |
| exeIdx | input | IDX_W | Slot being executed |
| exeAddr | input | ADDR_W | Store address |
| exeData | input | DATA_W | Store data |
| exeSize | input | SIZE_W | Byte count 0..8 |
| exeCond | input | 1 | Store-conditional |
| exeFault | input | 1 | Execution faulted |
| exePrefetch | input | 1 | Prefetch store, no write |
| commitValid | input | 1 | Commit strobe |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| squashValid | input | 1 | Squash strobe |
| squashSeq | input | SEQ_W | Entries younger than this are removed |
| wrValid | output | 1 | Cache write request |
| wrReady | input | 1 | Cache accepts the request |
| wrIdx | output | IDX_W | Slot of the request |
| wrAddr | output | ADDR_W | Request address |
| wrData | output | DATA_W | Request data |
| wrMask | output | DATA_W/8 | Byte mask |
| wrLqTail | output | LQ_W | Recorded load-queue tail |
| cplValid | input | 1 | Store completion strobe |
| cplIdx | input | IDX_W | Completed slot |
| stallSet | input | 1 | Register a load stalled on a store |
| stallSeq | input | SEQ_W | Sequence number of the blocking store |
| stallLoadIdx | input | LQ_W | Index of the stalled load |
| replayValid | output | 1 | Replay the stalled load |
| replayLoadIdx | output | LQ_W | Load to replay |

## Verification
The two functions that can land in the same cycle are a commit, which marks more stores writable, and a completion at the head, which retires entries. The bench issues both in one clock while the oldest store is outstanding and a zero-size store behind it has already completed. It then judges the result at the ports: `sqFull` must drop, because two slots retire at once, and in the very next cycle the first newly committed store must appear on the write request with its own mask. A squash issued in the same cycle as a completion at the head is judged the same way, through `allocIdx` and `sqEmpty`.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Strobes sent from the control to the entry storage.
  typedef struct packed {
    logic allocWe;   // write sequence number and load tag at the tail slot
    logic exeWe;     // write execute payload at the executed slot
  } sqStrobe_t;

endpackage

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int SLOTS  = 5,
  parameter int IDX_W  = 3,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int LQ_W   = 3,
  parameter int SIZE_W = 4
) (
  input  logic                              clk,
  input  sqStrobe_t                         strobe,
  input  logic [IDX_W-1:0]                  allocIdx,
  input  logic [SEQ_W-1:0]                  allocSeq,
  input  logic [LQ_W-1:0]                   allocLqTail,
  input  logic [IDX_W-1:0]                  exeIdx,
  input  logic [ADDR_W-1:0]                 exeAddr,
  input  logic [DATA_W-1:0]                 exeData,
  input  logic [SIZE_W-1:0]                 exeSize,
  input  logic                              exePrefetch,
  input  logic [IDX_W-1:0]                  wbIdx,
  output logic [SLOTS-1:0][SEQ_W-1:0]       seqArr,
  output logic [ADDR_W-1:0]                 wbAddr,
  output logic [DATA_W-1:0]                 wbData,
  output logic [DATA_W/8-1:0]               wbMask,
  output logic [SIZE_W-1:0]                 wbSize,
  output logic                              wbPrefetch,
  output logic [LQ_W-1:0]                   wbLqTail
);

  localparam int MASK_W = DATA_W / 8;
  localparam int LO_W   = $clog2(MASK_W);
  localparam int WIDE_W = 2 * MASK_W;

  logic [SLOTS-1:0][ADDR_W-1:0] addrArr;
  logic [SLOTS-1:0][DATA_W-1:0] dataArr;
  logic [SLOTS-1:0][SIZE_W-1:0] sizeArr;
  logic [SLOTS-1:0]             pfArr;
  logic [SLOTS-1:0][LQ_W-1:0]   lqArr;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.allocWe && allocIdx == IDX_W'(i)) begin
        seqArr[i] <= allocSeq;
        lqArr[i]  <= allocLqTail;
      end
      if (strobe.exeWe && exeIdx == IDX_W'(i)) begin
        addrArr[i] <= exeAddr;
        dataArr[i] <= exeData;
        sizeArr[i] <= exeSize;
        pfArr[i]   <= exePrefetch;
      end
    end
  end

  logic [WIDE_W-1:0] wideMask;

  always_comb begin
    wbAddr     = addrArr[wbIdx];
    wbData     = dataArr[wbIdx];
    wbSize     = sizeArr[wbIdx];
    wbPrefetch = pfArr[wbIdx];
    wbLqTail   = lqArr[wbIdx];
    wideMask   = (WIDE_W'(1) << wbSize) - WIDE_W'(1);
    wideMask   = wideMask << wbAddr[LO_W-1:0];
    wbMask     = wideMask[MASK_W-1:0];
  end

endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int SLOTS  = 5,
  parameter int IDX_W  = 3,
  parameter int SEQ_W  = 16,
  parameter int LQ_W   = 3,
  parameter int SIZE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        allocValid,
  input  logic                        exeValid,
  input  logic [IDX_W-1:0]            exeIdx,
  input  logic                        exeCond,
  input  logic                        exeFault,
  input  logic                        commitValid,
  input  logic [SEQ_W-1:0]            commitSeq,
  input  logic                        squashValid,
  input  logic [SEQ_W-1:0]            squashSeq,
  input  logic                        wrReady,
  input  logic                        cplValid,
  input  logic [IDX_W-1:0]            cplIdx,
  input  logic                        stallSet,
  input  logic [SEQ_W-1:0]            stallSeq,
  input  logic [LQ_W-1:0]             stallLoadIdx,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seqArr,
  input  logic [SIZE_W-1:0]           wbSize,
  input  logic                        wbPrefetch,
  output sqStrobe_t                   strobe,
  output logic [IDX_W-1:0]            tail,
  output logic [IDX_W-1:0]            wbPtr,
  output logic                        sqFull,
  output logic                        sqEmpty,
  output logic                        wrValid,
  output logic                        replayValid,
  output logic [LQ_W-1:0]             replayLoadIdx
);

  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [IDX_W-1:0] head;
  logic [SLOTS-1:0] valid, writable, done;
  logic [CNT_W-1:0] pending;
  logic             stalled;
  logic [SEQ_W-1:0] stallSeqReg;
  logic [LQ_W-1:0]  stallLoadReg;

  function automatic logic [IDX_W-1:0] incIdx(input logic [IDX_W-1:0] v);
    return (int'(v) == SLOTS - 1) ? '0 : v + IDX_W'(1);
  endfunction

  int               cnt;
  logic [SLOTS-1:0] commitMark, scMark, markNew, writableNext;
  logic [SLOTS-1:0] cplMask, doneNext, retireMask, killMask, allocBit;
  logic [SLOTS-1:0] seqMatch;
  logic [IDX_W-1:0] cPos, rPos, sPos, newHead, newTail;
  logic             cStop, rStop, sStop;
  logic             wbLive, wbZero, wbPf, wrFire, wbAdvance, allocFire, stallHit;
  logic [CNT_W-1:0] pendingNext;

  assign sqEmpty = (tail == head);
  assign sqFull  = (incIdx(tail) == head);

  // Commit scan from the head: stop at the first non-writable younger entry.
  always_comb begin
    cnt        = (int'(tail) - int'(head) + SLOTS) % SLOTS;
    commitMark = '0;
    cStop      = 1'b0;
    cPos       = head;
    for (int k = 0; k < SLOTS; k++) begin
      cPos = IDX_W'((int'(head) + k) % SLOTS);
      if (commitValid && k < cnt && !cStop && !writable[cPos]) begin
        if (seqArr[cPos] > commitSeq) cStop = 1'b1;
        else                          commitMark[cPos] = 1'b1;
      end
    end
  end

  // Store-conditional becomes writable at a clean execute.
  always_comb begin
    scMark = '0;
    if (exeValid && exeCond && !exeFault && valid[exeIdx] &&
        !writable[exeIdx] && !commitMark[exeIdx])
      scMark[exeIdx] = 1'b1;
    markNew      = commitMark | scMark;
    writableNext = writable | markNew;
  end

  // Write-back stage: one decision per cycle at the write-back pointer.
  always_comb begin
    wbLive    = (pending != '0) && (wbPtr != tail) && valid[wbPtr] &&
                writable[wbPtr] && !done[wbPtr];
    wbZero    = wbLive && (wbSize == '0);
    wbPf      = wbLive && !wbZero && wbPrefetch;
    wrValid   = wbLive && !wbZero && !wbPf;
    wrFire    = wrValid && wrReady;
    wbAdvance = wbZero || wbPf || wrFire;
  end

  // Completions: external strobe plus in-place completions.
  always_comb begin
    cplMask = '0;
    if (cplValid && valid[cplIdx] && !done[cplIdx]) cplMask[cplIdx] = 1'b1;
    if (wbZero || wbPf) cplMask[wbPtr] = 1'b1;
    doneNext    = done | cplMask;
    pendingNext = CNT_W'(int'(pending) + $countones(markNew) - $countones(cplMask));
  end

  // Retire across the run of completed entries at the head.
  always_comb begin
    retireMask = '0;
    rStop      = 1'b0;
    newHead    = head;
    rPos       = head;
    for (int k = 0; k < SLOTS; k++) begin
      rPos = IDX_W'((int'(head) + k) % SLOTS);
      if (k < cnt && !rStop) begin
        if (doneNext[rPos]) begin
          retireMask[rPos] = 1'b1;
          newHead          = incIdx(rPos);
        end else begin
          rStop = 1'b1;
        end
      end
    end
  end

  // Squash walk from the tail backwards, halting at a writable entry.
  always_comb begin
    killMask = '0;
    sStop    = 1'b0;
    newTail  = tail;
    sPos     = tail;
    for (int k = 0; k < SLOTS; k++) begin
      sPos = IDX_W'((int'(tail) - 1 - k + 2 * SLOTS) % SLOTS);
      if (squashValid && k < cnt && !sStop) begin
        if (writableNext[sPos] || !(seqArr[sPos] > squashSeq)) begin
          sStop = 1'b1;
        end else begin
          killMask[sPos] = 1'b1;
          newTail        = sPos;
        end
      end
    end
  end

  always_comb begin
    allocFire = allocValid && !sqFull && !squashValid;
    allocBit  = '0;
    if (allocFire) allocBit[tail] = 1'b1;
    strobe.allocWe = allocFire;
    strobe.exeWe   = exeValid && valid[exeIdx];
    for (int i = 0; i < SLOTS; i++) seqMatch[i] = (seqArr[i] == stallSeqReg);
    stallHit = stalled && ((wrFire && seqMatch[wbPtr]) || |(cplMask & seqMatch));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head          <= '0;
      wbPtr         <= '0;
      tail          <= '0;
      valid         <= '0;
      writable      <= '0;
      done          <= '0;
      pending       <= '0;
      stalled       <= 1'b0;
      stallSeqReg   <= '0;
      stallLoadReg  <= '0;
      replayValid   <= 1'b0;
      replayLoadIdx <= '0;
    end else begin
      head     <= newHead;
      wbPtr    <= wbAdvance ? incIdx(wbPtr) : wbPtr;
      tail     <= squashValid ? newTail : (allocFire ? incIdx(tail) : tail);
      valid    <= (valid & ~retireMask & ~killMask) | allocBit;
      writable <= writableNext & ~retireMask & ~killMask & ~allocBit;
      done     <= doneNext & ~retireMask & ~killMask & ~allocBit;
      pending  <= pendingNext;
      if (stallSet) begin
        stalled      <= 1'b1;
        stallSeqReg  <= stallSeq;
        stallLoadReg <= stallLoadIdx;
      end else if (stallHit) begin
        stalled <= 1'b0;
      end
      replayValid   <= stallHit;
      replayLoadIdx <= stallLoadReg;
    end
  end

  // R2: a full queue ignores allocation
  a_r2_full_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (sqFull && allocValid && !squashValid) |=> $stable(tail));

  // R7: a refused request is presented again for the same slot
  a_r7_hold_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !wrReady) |=> (wrValid && $stable(wbPtr)));

  // R1: nothing is requested from an empty queue
  a_r1_empty_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    sqEmpty |-> !wrValid);

  // R8: a zero-byte store never reaches the cache
  a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid |-> (wbSize != '0));

  // R11: a replay follows only a registered stall
  a_r11_replay_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    replayValid |-> $past(stalled));

  // R10: squash never removes a writable entry
  a_r10_keep_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (killMask & writableNext) == '0);

endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int CAPACITY = 4,
  parameter int SEQ_W    = 16,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int LQ_W     = 3,
  parameter int SIZE_W   = 4,
  localparam int SLOTS   = CAPACITY + 1,
  localparam int IDX_W   = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                allocValid,
  input  logic [SEQ_W-1:0]    allocSeq,
  input  logic [LQ_W-1:0]     allocLqTail,
  output logic [IDX_W-1:0]    allocIdx,
  output logic                sqFull,
  output logic                sqEmpty,
  input  logic                exeValid,
  input  logic [IDX_W-1:0]    exeIdx,
  input  logic [ADDR_W-1:0]   exeAddr,
  input  logic [DATA_W-1:0]   exeData,
  input  logic [SIZE_W-1:0]   exeSize,
  input  logic                exeCond,
  input  logic                exeFault,
  input  logic                exePrefetch,
  input  logic                commitValid,
  input  logic [SEQ_W-1:0]    commitSeq,
  input  logic                squashValid,
  input  logic [SEQ_W-1:0]    squashSeq,
  output logic                wrValid,
  input  logic                wrReady,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W/8-1:0] wrMask,
  output logic [LQ_W-1:0]     wrLqTail,
  input  logic                cplValid,
  input  logic [IDX_W-1:0]    cplIdx,
  input  logic                stallSet,
  input  logic [SEQ_W-1:0]    stallSeq,
  input  logic [LQ_W-1:0]     stallLoadIdx,
  output logic                replayValid,
  output logic [LQ_W-1:0]     replayLoadIdx
);

  sqStrobe_t                   strobe;
  logic [IDX_W-1:0]            tail, wbPtr;
  logic [SLOTS-1:0][SEQ_W-1:0] seqArr;
  logic [SIZE_W-1:0]           wbSize;
  logic                        wbPrefetch;

  assign allocIdx = tail;
  assign wrIdx    = wbPtr;

  sq_ctrl #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .LQ_W(LQ_W), .SIZE_W(SIZE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid),
    .exeValid(exeValid), .exeIdx(exeIdx), .exeCond(exeCond), .exeFault(exeFault),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .wrReady(wrReady), .cplValid(cplValid), .cplIdx(cplIdx),
    .stallSet(stallSet), .stallSeq(stallSeq), .stallLoadIdx(stallLoadIdx),
    .seqArr(seqArr), .wbSize(wbSize), .wbPrefetch(wbPrefetch),
    .strobe(strobe), .tail(tail), .wbPtr(wbPtr),
    .sqFull(sqFull), .sqEmpty(sqEmpty), .wrValid(wrValid),
    .replayValid(replayValid), .replayLoadIdx(replayLoadIdx)
  );

  sq_data #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .LQ_W(LQ_W), .SIZE_W(SIZE_W)
  ) u_data (
    .clk(clk), .strobe(strobe),
    .allocIdx(tail), .allocSeq(allocSeq), .allocLqTail(allocLqTail),
    .exeIdx(exeIdx), .exeAddr(exeAddr), .exeData(exeData), .exeSize(exeSize),
    .exePrefetch(exePrefetch), .wbIdx(wbPtr),
    .seqArr(seqArr), .wbAddr(wrAddr), .wbData(wrData), .wbMask(wrMask),
    .wbSize(wbSize), .wbPrefetch(wbPrefetch), .wbLqTail(wrLqTail)
  );

endmodule

// File: tb/tb_store_queue.sv
module tb_store_queue;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        allocValid;
  logic [15:0] allocSeq;
  logic [2:0]  allocLqTail;
  logic [2:0]  allocIdx;
  logic        sqFull, sqEmpty;
  logic        exeValid;
  logic [2:0]  exeIdx;
  logic [15:0] exeAddr;
  logic [63:0] exeData;
  logic [3:0]  exeSize;
  logic        exeCond, exeFault, exePrefetch;
  logic        commitValid;
  logic [15:0] commitSeq;
  logic        squashValid;
  logic [15:0] squashSeq;
  logic        wrValid, wrReady;
  logic [2:0]  wrIdx;
  logic [15:0] wrAddr;
  logic [63:0] wrData;
  logic [7:0]  wrMask;
  logic [2:0]  wrLqTail;
  logic        cplValid;
  logic [2:0]  cplIdx;
  logic        stallSet;
  logic [15:0] stallSeq;
  logic [2:0]  stallLoadIdx;
  logic        replayValid;
  logic [2:0]  replayLoadIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  store_queue dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 0; exeValid = 0; exeCond = 0; exeFault = 0; exePrefetch = 0;
    commitValid = 0; squashValid = 0; cplValid = 0; stallSet = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic alloc(input logic [15:0] s, input logic [2:0] lq);
    idle(); allocValid = 1; allocSeq = s; allocLqTail = lq; tick(); idle();
  endtask

  task automatic exe(input logic [2:0] i, input logic [15:0] a, input logic [63:0] d,
                     input logic [3:0] sz, input logic c, input logic f, input logic p);
    idle(); exeValid = 1; exeIdx = i; exeAddr = a; exeData = d; exeSize = sz;
    exeCond = c; exeFault = f; exePrefetch = p; tick(); idle();
  endtask

  task automatic complete(input logic [2:0] i);
    idle(); cplValid = 1; cplIdx = i; tick(); idle();
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); wrReady = 0;
    allocSeq = 0; allocLqTail = 0; exeIdx = 0; exeAddr = 0; exeData = 0; exeSize = 0;
    commitSeq = 0; squashSeq = 0; cplIdx = 0; stallSeq = 0; stallLoadIdx = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 empty", sqEmpty, 1); chk("R1 full", sqFull, 0); chk("R1 allocIdx", allocIdx, 0);
    chk("R1 wrValid", wrValid, 0); chk("R1 replay", replayValid, 0);

    // R2 fill four slots, then try one more
    alloc(10, 1); alloc(11, 2); alloc(12, 3); alloc(13, 4);
    chk("R2 allocIdx after four", allocIdx, 4); chk("R2 full", sqFull, 1);
    alloc(99, 7);
    chk("R2 alloc ignored when full", allocIdx, 4);

    exe(0, 16'h0104, 64'h11, 4, 0, 0, 0);
    exe(1, 16'h0000, 64'h0, 0, 0, 0, 0);
    exe(2, 16'h0201, 64'h22, 2, 0, 0, 0);
    exe(3, 16'h0300, 64'h33, 8, 0, 0, 0);
    chk("R3 no request before commit", wrValid, 0);

    // R4 commit up to seq 11
    commitValid = 1; commitSeq = 11; tick(); idle();
    chk("R4 request after commit", wrValid, 1);
    chk("R6 wrIdx", wrIdx, 0); chk("R6 mask size4 lo4", wrMask, 8'hF0);
    chk("R6 addr", wrAddr, 16'h0104); chk("R6 data", wrData, 64'h11);
    chk("R6 lq tag", wrLqTail, 1);
    tick();
    chk("R7 held valid", wrValid, 1); chk("R7 held idx", wrIdx, 0);
    wrReady = 1; tick(); wrReady = 0;
    chk("R8 zero-size sends nothing", wrValid, 0);
    tick();
    chk("R4 stop at seq 12", wrValid, 0);
    chk("R9 out-of-order completion keeps head", sqFull, 1);

    // R12 completion of head and commit in the same cycle
    cplValid = 1; cplIdx = 0; commitValid = 1; commitSeq = 13; tick(); idle();
    chk("R12 head retired run", sqFull, 0);
    chk("R12 committed store requested", wrValid, 1);
    chk("R12 idx", wrIdx, 2); chk("R6 mask size2 lo1", wrMask, 8'h06);
    wrReady = 1; tick();
    chk("R6 next in order", wrIdx, 3); chk("R6 mask size8", wrMask, 8'hFF);
    tick(); wrReady = 0;
    chk("R6 drained", wrValid, 0);
    complete(3);
    chk("R9 younger done alone keeps queue", sqEmpty, 0);
    complete(2);
    chk("R9 run retires", sqEmpty, 1);

    // R10 squash
    alloc(20, 0); alloc(21, 1); alloc(22, 2);
    exe(4, 16'h0007, 64'h44, 1, 0, 0, 0);
    commitValid = 1; commitSeq = 20; tick(); idle();
    squashValid = 1; squashSeq = 20; allocValid = 1; allocSeq = 99; tick(); idle();
    chk("R10 squash trims tail", allocIdx, 0);
    squashValid = 1; squashSeq = 5; tick(); idle();
    chk("R10 writable kept", allocIdx, 0); chk("R10 not empty", sqEmpty, 0);
    chk("R6 mask size1 lo7", wrMask, 8'h80); chk("R10 survivor idx", wrIdx, 4);
    wrReady = 1; tick(); wrReady = 0;
    complete(4);
    chk("R9 empty after squash case", sqEmpty, 1);

    // R5 store-conditional
    alloc(30, 0); alloc(31, 0);
    exe(1, 16'h0000, 64'h0, 4, 1, 1, 0);
    exe(0, 16'h0000, 64'h55, 4, 1, 0, 0);
    chk("R5 clean SC requested", wrValid, 1); chk("R5 idx", wrIdx, 0);
    chk("R5 mask", wrMask, 8'h0F);
    wrReady = 1; tick(); wrReady = 0;
    chk("R5 faulted SC not requested", wrValid, 0);
    cplValid = 1; cplIdx = 0; squashValid = 1; squashSeq = 30; tick(); idle();
    chk("R10 squash with completion", allocIdx, 1); chk("R9 empty", sqEmpty, 1);

    // R8 prefetch and R11 stall via send
    alloc(40, 3); alloc(41, 4);
    exe(1, 16'h0000, 64'h0, 4, 0, 0, 1);
    exe(2, 16'h0010, 64'h66, 2, 0, 0, 0);
    stallSet = 1; stallSeq = 41; stallLoadIdx = 6;
    commitValid = 1; commitSeq = 41; tick(); idle();
    chk("R8 prefetch sends nothing", wrValid, 0);
    tick();
    chk("R8 next after prefetch", wrIdx, 2); chk("R6 mask size2 lo0", wrMask, 8'h03);
    chk("R11 no replay yet", replayValid, 0);
    wrReady = 1; tick(); wrReady = 0;
    chk("R11 replay on send", replayValid, 1); chk("R11 load idx", replayLoadIdx, 6);
    tick();
    chk("R11 pulse one cycle", replayValid, 0);
    complete(2);
    chk("R8 prefetch retired", sqEmpty, 1);

    // R11 stall via completion of a zero-size store
    alloc(50, 0);
    exe(3, 16'h0000, 64'h0, 0, 0, 0, 0);
    stallSet = 1; stallSeq = 50; stallLoadIdx = 2;
    commitValid = 1; commitSeq = 50; tick(); idle();
    tick();
    chk("R11 replay on completion", replayValid, 1); chk("R11 load idx 2", replayLoadIdx, 2);
    chk("R8 zero-size retired", sqEmpty, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule